// File: doc/BRIEF.md
# Host Mailbox Buffer Interface

This block sits between a host processor and a small local controller. Two one-byte mailboxes pass bytes between them. The host writes into the inbox and the local side fetches from it. The local side loads the outbox and the host reads from it.

An 8-bit status byte tells each side what is pending. It holds a user nibble, two flags and the two "full" flags. The host reaches the block over an 8-bit bus with chip select, one address line and active-low read and write strobes. The local side has load, fetch, status-nibble write and flag-0 write controls. The two "full" flags are brought out for the pin-multiplexing logic.

The host signals are asynchronous to the local clock, so every host input is sampled through two flops. Host-driven flag changes happen only once the trailing (rising) edge of a strobe has been seen. While the host reads the status byte, local writes to the user nibble and to flag 0 are held back. They take effect once that read has ended.

Top module: `host_mailbox`

## Requirements
- R1: The reset input passes through a two-stage synchronizer. After reset the status byte reads 0x00, the inbox reads 0x00, and both full flags are 0.
- R2: A host write with chip select low sets the inbox-full flag and stores the bus byte in the inbox. It also records the address line in F1 (status bit 3): 0 for data, 1 for command.
- R3: A local fetch clears the inbox-full flag. If the fetch lands in the same cycle as a host write's trailing-edge update, the write wins: the flag stays 1 and the inbox holds the new byte.
- R4: A local load stores a byte in the outbox and sets the outbox-full flag. A host read with address 0 returns the outbox and clears that flag at its trailing edge. A load in the same cycle as that clear wins, and the flag stays 1.
- R5: A host read with address 1 returns the status byte with the layout {U[3:0], F1, F0, IBF, OBF}, from bit 7 down to bit 0. Here U is the user nibble, IBF is the inbox-full flag and OBF is the outbox-full flag. While no read is active, the bus output is 0 and its enable is low.
- R6: A local status write copies bits 7..4 of its operand into status bits 7..4 and leaves status bits 3..0 unchanged. A local flag-0 write sets F0 (status bit 2).
- R7: The full flags change only after the trailing edge of the host strobe. While a strobe is still low they keep their old value.
- R8: While the host reads the status byte, local writes to status bits 7..4 and to F0 are held pending. The byte seen on the bus does not change during the read, and the pending write is applied after the read strobe ends.
- R9: Host strobes with chip select high change neither the flags nor the inbox contents.
- R10: The inbox and the outbox are separate. A host write does not alter the byte the host reads back from the outbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Host address line: 0 selects data, 1 selects status or command |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_dout_oe | output | 1 | High while a selected host read is active |
| out_load | input | 1 | Local load of the outbox |
| out_data | input | 8 | Byte to load into the outbox |
| in_fetch | input | 1 | Local fetch of the inbox, clears the inbox-full flag |
| in_data | output | 8 | Current inbox contents |
| sts_wr | input | 1 | Local write of the user status nibble |
| sts_acc | input | 8 | Operand for the status write; bits 7..4 are used |
| f0_wr | input | 1 | Local write of flag 0 |
| f0_val | input | 1 | Value written to flag 0 |
| ibf | output | 1 | Inbox-full flag |
| obf | output | 1 | Outbox-full flag |

## Verification
Two pairs of actions can collide in one cycle. The first pair is a local fetch and the update from a host write's trailing edge. The second is a local load and the outbox-full clear after a host data read. The bench counts the synchronizer and edge-detect registers to find the one clock edge where the host update lands, and it drives the local pulse exactly on that edge. It then expects the set to win: the full flag stays high, and the new byte is the one that can be read. A third overlap is a local status write during a host status read. There the bench checks that the byte on the bus stays frozen until the strobe ends, and that a later read shows the deferred value.

// File: rtl/host_mailbox.sv
module host_mailbox #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs_n,
  input  logic          host_a0,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_dout_oe,
  input  logic          out_load,
  input  logic [DW-1:0] out_data,
  input  logic          in_fetch,
  output logic [DW-1:0] in_data,
  input  logic          sts_wr,
  input  logic [DW-1:0] sts_acc,
  input  logic          f0_wr,
  input  logic          f0_val,
  output logic          ibf,
  output logic          obf
);
  localparam int UW = DW - 4;
  localparam int BW = DW + 2;

  logic [1:0] rsync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};

  assign rst_i = ~rsync[1];

  logic [1:0]    wr_p, rd_p;
  logic          wr_d, rd_d;
  logic [BW-1:0] bus_s1, bus_s2;
  logic          s2_cs_n, s2_a0;
  logic [DW-1:0] s2_din;

  assign {s2_cs_n, s2_a0, s2_din} = bus_s2;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      wr_p   <= 2'b11;
      rd_p   <= 2'b11;
      wr_d   <= 1'b1;
      rd_d   <= 1'b1;
      bus_s1 <= '1;
      bus_s2 <= '1;
    end else begin
      wr_p   <= {wr_p[0], host_wr_n};
      rd_p   <= {rd_p[0], host_rd_n};
      wr_d   <= wr_p[1];
      rd_d   <= rd_p[1];
      bus_s1 <= {host_cs_n, host_a0, host_din};
      bus_s2 <= bus_s1;
    end
  end

  logic          wr_sel, wr_a0, rd_sel, rd_a0;
  logic [DW-1:0] wr_dat;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      wr_sel <= 1'b0;
      wr_a0  <= 1'b0;
      wr_dat <= '0;
      rd_sel <= 1'b0;
      rd_a0  <= 1'b0;
    end else begin
      if (!wr_p[1]) begin
        wr_sel <= ~s2_cs_n;
        wr_a0  <= s2_a0;
        wr_dat <= s2_din;
      end
      if (!rd_p[1]) begin
        rd_sel <= ~s2_cs_n;
        rd_a0  <= s2_a0;
      end
    end
  end

  logic wr_rise, rd_rise, lock;

  assign wr_rise = wr_p[1] & ~wr_d & wr_sel;
  assign rd_rise = rd_p[1] & ~rd_d & rd_sel;
  assign lock    = (~host_rd_n & ~host_cs_n & host_a0)
                 | (~rd_p[1] & ~s2_cs_n & s2_a0);

  logic [DW-1:0] ibuf, obuf;
  logic          f1;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ibuf <= '0;
      ibf  <= 1'b0;
      f1   <= 1'b0;
    end else if (wr_rise) begin
      ibuf <= wr_dat;
      ibf  <= 1'b1;
      f1   <= wr_a0;
    end else if (in_fetch) begin
      ibf  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      obuf <= '0;
      obf  <= 1'b0;
    end else if (out_load) begin
      obuf <= out_data;
      obf  <= 1'b1;
    end else if (rd_rise && !rd_a0) begin
      obf  <= 1'b0;
    end
  end

  logic [UW-1:0] ust, pend_u;
  logic          f0, pend_uv, pend_f0v, pend_f0;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      ust      <= '0;
      f0       <= 1'b0;
      pend_u   <= '0;
      pend_uv  <= 1'b0;
      pend_f0  <= 1'b0;
      pend_f0v <= 1'b0;
    end else if (lock) begin
      if (sts_wr) begin
        pend_u  <= sts_acc[DW-1:4];
        pend_uv <= 1'b1;
      end
      if (f0_wr) begin
        pend_f0  <= f0_val;
        pend_f0v <= 1'b1;
      end
    end else begin
      if (sts_wr)       ust <= sts_acc[DW-1:4];
      else if (pend_uv) ust <= pend_u;
      if (f0_wr)         f0 <= f0_val;
      else if (pend_f0v) f0 <= pend_f0;
      pend_uv  <= 1'b0;
      pend_f0v <= 1'b0;
    end
  end

  logic [DW-1:0] sts;

  assign sts          = {ust, f1, f0, ibf, obf};
  assign in_data      = ibuf;
  assign host_dout_oe = ~host_cs_n & ~host_rd_n;
  assign host_dout    = host_dout_oe ? (host_a0 ? sts : obuf) : '0;

endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_i,
  input logic          host_wr_n,
  input logic          in_fetch,
  input logic          out_load,
  input logic          ibf,
  input logic          obf,
  input logic          lock,
  input logic          wr_rise,
  input logic          sts_wr,
  input logic [DW-1:0] sts_acc,
  input logic [DW-1:0] sts
);
  AST_WRITE_SETS_IBF: assert property (@(posedge clk) disable iff (rst_i) wr_rise |=> ibf); // R2
  AST_FETCH_CLEARS_IBF: assert property (@(posedge clk) disable iff (rst_i) in_fetch && !wr_rise |=> !ibf); // R3
  AST_LOAD_SETS_OBF: assert property (@(posedge clk) disable iff (rst_i) out_load |=> obf); // R4
  AST_STS_NIBBLE_COPY: assert property (@(posedge clk) disable iff (rst_i) sts_wr && !lock |=> sts[DW-1:4] == $past(sts_acc[DW-1:4])); // R6
  AST_IBF_AFTER_TRAILING: assert property (@(posedge clk) disable iff (rst_i) $rose(ibf) |-> $past(host_wr_n)); // R7
  AST_STS_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (rst_i) lock && $past(lock) |-> $stable({sts[DW-1:4], sts[2]})); // R8
endmodule

bind host_mailbox host_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_i(rst_i), .host_wr_n(host_wr_n), .in_fetch(in_fetch),
  .out_load(out_load), .ibf(ibf), .obf(obf), .lock(lock), .wr_rise(wr_rise),
  .sts_wr(sts_wr), .sts_acc(sts_acc), .sts(sts)
);

// File: tb/tb_host_mailbox.sv
module tb_host_mailbox;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs_n = 1'b1, host_a0 = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_din = 8'h00;
  logic [7:0] host_dout;
  logic       host_dout_oe;
  logic       out_load = 1'b0;
  logic [7:0] out_data = 8'h00;
  logic       in_fetch = 1'b0;
  logic [7:0] in_data;
  logic       sts_wr = 1'b0;
  logic [7:0] sts_acc = 8'h00;
  logic       f0_wr = 1'b0, f0_val = 1'b0;
  logic       ibf, obf;

  always #10 clk = ~clk;

  host_mailbox dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_a0(host_a0),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_din(host_din),
    .host_dout(host_dout), .host_dout_oe(host_dout_oe), .out_load(out_load),
    .out_data(out_data), .in_fetch(in_fetch), .in_data(in_data),
    .sts_wr(sts_wr), .sts_acc(sts_acc), .f0_wr(f0_wr), .f0_val(f0_val),
    .ibf(ibf), .obf(obf)
  );

  int         n_vec = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       obs_ev;
  bit         done = 1'b0;

  always begin
    @(obs_ev);
    begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (obs !== e) begin
        n_bad++;
        $display("FAIL %s actual=%02h expected=%02h", t, obs, e);
      end
    end
  end

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] e);
    exp_q.push_back(e);
    tag_q.push_back(t);
    obs = act;
    ->obs_ev;
    #1;
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic cs_n, input logic a, input logic [7:0] d,
                            input bit fetch_same, input string mid_tag,
                            input logic mid_ibf);
    tick();
    host_cs_n = cs_n; host_a0 = a; host_din = d; host_wr_n = 1'b0;
    tick(4);
    if (mid_tag != "") check(mid_tag, {7'd0, ibf}, {7'd0, mid_ibf});
    host_wr_n = 1'b1;
    tick(2);
    if (fetch_same) in_fetch = 1'b1;
    tick();
    in_fetch = 1'b0;
    host_cs_n = 1'b1;
    tick(2);
  endtask

  task automatic host_read(input logic cs_n, input logic a, input string t,
                           input logic [7:0] e, input bit load_same,
                           input logic [7:0] ld);
    tick();
    host_cs_n = cs_n; host_a0 = a; host_rd_n = 1'b0;
    tick(4);
    if (t != "") check(t, host_dout, e);
    host_rd_n = 1'b1;
    tick(2);
    if (load_same) begin out_load = 1'b1; out_data = ld; end
    tick();
    out_load = 1'b0;
    host_cs_n = 1'b1;
    tick(2);
  endtask

  task automatic pulse_fetch();
    tick(); in_fetch = 1'b1; tick(); in_fetch = 1'b0; tick();
  endtask

  task automatic pulse_load(input logic [7:0] d);
    tick(); out_load = 1'b1; out_data = d; tick(); out_load = 1'b0; tick();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check("R1 flags after reset", {6'd0, ibf, obf}, 8'h00);
    check("R1 inbox after reset", in_data, 8'h00);
    check("R5 bus idle", {host_dout_oe, host_dout[6:0]}, 8'h00);
    host_read(1'b0, 1'b1, "R1 status after reset", 8'h00, 1'b0, 8'h00);

    host_write(1'b0, 1'b0, 8'h5A, 1'b0, "R7 ibf low during strobe", 1'b0);
    check("R2 inbox data", in_data, 8'h5A);
    host_read(1'b0, 1'b1, "R2 R5 status after data write", 8'h02, 1'b0, 8'h00);
    pulse_fetch();
    check("R3 fetch clears ibf", {7'd0, ibf}, 8'h00);

    host_write(1'b0, 1'b1, 8'hC3, 1'b0, "", 1'b0);
    host_read(1'b0, 1'b1, "R2 command sets F1", 8'h0A, 1'b0, 8'h00);

    host_write(1'b0, 1'b0, 8'h77, 1'b1, "", 1'b0);
    check("R3 write beats fetch ibf", {7'd0, ibf}, 8'h01);
    check("R3 write beats fetch data", in_data, 8'h77);
    pulse_fetch();

    pulse_load(8'h9E);
    host_read(1'b0, 1'b1, "R4 status obf set", 8'h01, 1'b0, 8'h00);
    tick();
    host_cs_n = 1'b0; host_a0 = 1'b0; host_rd_n = 1'b0;
    tick(4);
    check("R4 data read", host_dout, 8'h9E);
    check("R7 obf held during read", {7'd0, obf}, 8'h01);
    host_rd_n = 1'b1;
    tick(4);
    host_cs_n = 1'b1;
    check("R4 read clears obf", {7'd0, obf}, 8'h00);

    pulse_load(8'h44);
    host_read(1'b0, 1'b0, "R4 data read 44", 8'h44, 1'b1, 8'h55);
    check("R4 load beats clear", {7'd0, obf}, 8'h01);
    host_read(1'b0, 1'b0, "R4 data read 55", 8'h55, 1'b0, 8'h00);

    pulse_load(8'h11);
    host_write(1'b0, 1'b0, 8'hEE, 1'b0, "", 1'b0);
    host_read(1'b0, 1'b0, "R10 outbox kept", 8'h11, 1'b0, 8'h00);
    pulse_fetch();

    pulse_load(8'h20);
    host_write(1'b0, 1'b1, 8'h01, 1'b0, "", 1'b0);
    host_read(1'b0, 1'b1, "R5 status 0B", 8'h0B, 1'b0, 8'h00);
    tick(); sts_wr = 1'b1; sts_acc = 8'hA5; tick(); sts_wr = 1'b0; tick();
    host_read(1'b0, 1'b1, "R6 nibble copy", 8'hAB, 1'b0, 8'h00);
    tick(); f0_wr = 1'b1; f0_val = 1'b1; tick(); f0_wr = 1'b0; tick();
    host_read(1'b0, 1'b1, "R6 f0 set", 8'hAF, 1'b0, 8'h00);

    tick();
    host_cs_n = 1'b0; host_a0 = 1'b1; host_rd_n = 1'b0;
    tick(3);
    sts_wr = 1'b1; sts_acc = 8'h3C; f0_wr = 1'b1; f0_val = 1'b0;
    tick();
    sts_wr = 1'b0; f0_wr = 1'b0;
    tick(2);
    check("R8 status frozen in read", host_dout, 8'hAF);
    host_rd_n = 1'b1;
    tick(4);
    host_cs_n = 1'b1;
    host_read(1'b0, 1'b1, "R8 deferred applied", 8'h3B, 1'b0, 8'h00);

    host_write(1'b1, 1'b0, 8'h99, 1'b0, "", 1'b1);
    check("R9 inbox kept", in_data, 8'h01);
    host_read(1'b1, 1'b0, "", 8'h00, 1'b0, 8'h00);
    check("R9 flags kept", {6'd0, ibf, obf}, 8'h03);
    host_read(1'b0, 1'b1, "R9 status kept", 8'h3B, 1'b0, 8'h00);

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule